// File: doc/BRIEF.md
# External Memory Bus Controller

This block connects an embedded CPU's simple internal request bus to an asynchronous off-chip memory bus. It takes one read or write at a time and turns it into a timed sequence of active-low strobes. The off-chip bus has a 20-bit address, a 32-bit data path, four chip selects, one output enable and four byte-lane write enables. The upper internal address bits pick the chip select. The lower bits go out as the memory address.

A small register holds a wait-state count from 0 to 3, and every access is stretched by that many clocks. A read keeps its strobes low for one clock plus the wait states. The returned word is sampled on the edge that ends the strobe. A write drives its data for three clocks plus the wait states. The write enables are low only in the middle of that window, so the data has one clock of setup before the enables fall and one clock of hold after they rise. A one-clock done pulse follows each access, with the read word attached. Requests that arrive while an access or its done clock is in progress are held off.

Top module: `emc_bus_ctrl`

## Requirements
- R1: While and right after synchronous reset, every chip select, the output enable and every write enable are high, write data is not driven, done is low and the wait register reads 0.
- R2: During an access, exactly one chip select is low, with index req_addr[21:20], and mem_addr equals req_addr[19:0].
- R3: A read holds its chip select and mem_oe_n low for exactly 1+W consecutive clocks (W = wait count latched at acceptance), and all write enables stay high.
- R4: The read word on mem_rdata is sampled at the clock edge that ends the last strobe clock. It appears on req_rdata together with done and holds until the next read completes; writes leave it unchanged.
- R5: A write holds its chip select low and mem_wdata_oe high for exactly 3+W clocks, with mem_oe_n high. The write enables are low only from the second clock to the second-to-last clock of that window, which is 1+W clocks.
- R6: Write-enable bit i (lane i = data bits 8i+7..8i) goes low only when req_be[i] was set; a zero mask asserts none. mem_wdata equals req_wdata for the whole write.
- R7: req_done is a single-clock pulse in the clock right after the strobes release, and all strobes are high during it.
- R8: Request fields and req_valid are sampled only when the controller is idle. Changes or a held req_valid during an access or its done clock start no second access, so at least one idle clock with all strobes high follows the done clock.
- R9: cfg_we loads cfg_wdata into the wait register, readable on cfg_wait the next clock. A change made during an access does not alter that access's length; it applies from the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Bits 21:20 select chip, 19:0 memory address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane mask for writes |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 32 | Last captured read word |
| cfg_we | input | 1 | Wait register write strobe |
| cfg_wdata | input | 2 | New wait-state count |
| cfg_wait | output | 2 | Current wait-state count |
| mem_addr | output | 20 | External address |
| mem_wdata | output | 32 | External write data |
| mem_wdata_oe | output | 1 | High while write data is driven |
| mem_rdata | input | 32 | External read data |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 4 | Active-low byte write enables |

## Verification
The bench uses the default parameters: four chip selects, a 2-bit wait count and read and write base lengths of one and three clocks. This puts every wait value from 0 to 3 within reach for both access types, including the longest write of six clocks. It also lets every chip select and every byte-mask pattern occur, including the empty mask. The bench changes the request fields and rewrites the wait register in the middle of accesses, so the latching at acceptance is exercised as well.

// File: rtl/emc_pkg.sv
package emc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } emc_state_e;
endpackage

// File: rtl/emc_cs_decode.sv
module emc_cs_decode #(
  parameter int CS_N  = 4,
  parameter int SEL_W = $clog2(CS_N)
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CS_N-1:0]  cs_n_pat
);
  for (genvar k = 0; k < CS_N; k++) begin : g_cs
    assign cs_n_pat[k] = (sel != SEL_W'(k));
  end
endmodule

// File: rtl/emc_wait_reg.sv
module emc_wait_reg #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WAIT_W-1:0] wr_data,
  output logic [WAIT_W-1:0] wait_q
);
  always_ff @(posedge clk) begin
    if (rst)        wait_q <= '0;
    else if (wr_en) wait_q <= wr_data;
  end
endmodule

// File: rtl/emc_seq.sv
module emc_seq
  import emc_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32,
  parameter int CS_N    = 4,
  parameter int WAIT_W  = 2,
  parameter int RD_BASE = 1,
  parameter int WR_BASE = 3,
  parameter int SEL_W   = $clog2(CS_N),
  parameter int IADDR_W = ADDR_W + SEL_W,
  parameter int LANES   = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [IADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [LANES-1:0]   req_be,
  input  logic [WAIT_W-1:0]  wait_cfg,
  input  logic [CS_N-1:0]    cs_n_pat,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               req_done,
  output logic [DATA_W-1:0]  req_rdata,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               mem_wdata_oe,
  output logic [CS_N-1:0]    mem_cs_n,
  output logic               mem_oe_n,
  output logic [LANES-1:0]   mem_we_n
);
  localparam int MAX_BASE = (WR_BASE > RD_BASE) ? WR_BASE : RD_BASE;
  localparam int MAX_LEN  = MAX_BASE + (1 << WAIT_W) - 1;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  emc_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   len_m1;
  logic               is_wr;
  logic [LANES-1:0]   be_q;

  // Remaining strobe clocks after the first one.
  always_comb begin
    len_m1 = (req_write ? CNT_W'(WR_BASE) : CNT_W'(RD_BASE))
           + CNT_W'(wait_cfg) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      is_wr        <= 1'b0;
      be_q         <= '0;
      mem_cs_n     <= '1;
      mem_oe_n     <= 1'b1;
      mem_we_n     <= '1;
      mem_wdata_oe <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      req_done     <= 1'b0;
      req_rdata    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          req_done <= 1'b0;
          if (req_valid) begin
            state        <= ST_BUSY;
            cnt          <= len_m1;
            is_wr        <= req_write;
            be_q         <= req_be;
            mem_cs_n     <= cs_n_pat;
            mem_oe_n     <= req_write;
            mem_wdata_oe <= req_write;
            mem_addr     <= req_addr[ADDR_W-1:0];
            if (req_write) mem_wdata <= req_wdata;
          end
        end
        ST_BUSY: begin
          if (cnt == '0) begin
            state        <= ST_DONE;
            mem_cs_n     <= '1;
            mem_oe_n     <= 1'b1;
            mem_we_n     <= '1;
            mem_wdata_oe <= 1'b0;
            req_done     <= 1'b1;
            if (!is_wr) req_rdata <= mem_rdata;
          end else begin
            cnt      <= cnt - CNT_W'(1);
            // Enables stay high in the first and the last write clock.
            mem_we_n <= (is_wr && cnt != CNT_W'(1)) ? ~be_q : '1;
          end
        end
        ST_DONE: begin
          req_done <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/emc_bus_ctrl.sv
module emc_bus_ctrl #(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32,
  parameter int CS_N    = 4,
  parameter int WAIT_W  = 2,
  parameter int RD_BASE = 1,
  parameter int WR_BASE = 3,
  localparam int SEL_W   = $clog2(CS_N),
  localparam int IADDR_W = ADDR_W + SEL_W,
  localparam int LANES   = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [IADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [LANES-1:0]   req_be,
  output logic               req_done,
  output logic [DATA_W-1:0]  req_rdata,
  input  logic               cfg_we,
  input  logic [WAIT_W-1:0]  cfg_wdata,
  output logic [WAIT_W-1:0]  cfg_wait,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               mem_wdata_oe,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [CS_N-1:0]    mem_cs_n,
  output logic               mem_oe_n,
  output logic [LANES-1:0]   mem_we_n
);
  logic [CS_N-1:0] cs_n_pat;

  emc_cs_decode #(.CS_N(CS_N), .SEL_W(SEL_W)) u_dec (
    .sel      (req_addr[IADDR_W-1:ADDR_W]),
    .cs_n_pat (cs_n_pat)
  );

  emc_wait_reg #(.WAIT_W(WAIT_W)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .wait_q  (cfg_wait)
  );

  emc_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_N(CS_N), .WAIT_W(WAIT_W),
    .RD_BASE(RD_BASE), .WR_BASE(WR_BASE), .SEL_W(SEL_W),
    .IADDR_W(IADDR_W), .LANES(LANES)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_be       (req_be),
    .wait_cfg     (cfg_wait),
    .cs_n_pat     (cs_n_pat),
    .mem_rdata    (mem_rdata),
    .req_done     (req_done),
    .req_rdata    (req_rdata),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_wdata_oe (mem_wdata_oe),
    .mem_cs_n     (mem_cs_n),
    .mem_oe_n     (mem_oe_n),
    .mem_we_n     (mem_we_n)
  );
endmodule

// File: rtl/emc_bus_ctrl_chk.sv
module emc_bus_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int CS_N   = 4,
  parameter int WAIT_W = 2,
  parameter int LANES  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_done,
  input logic [DATA_W-1:0] req_rdata,
  input logic              cfg_we,
  input logic [WAIT_W-1:0] cfg_wait,
  input logic              mem_wdata_oe,
  input logic [CS_N-1:0]   mem_cs_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_we_n
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (&mem_cs_n && mem_oe_n && &mem_we_n && !mem_wdata_oe
             && !req_done && cfg_wait == '0));

  a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));

  a_r3_no_read_write_overlap: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> &mem_we_n);

  a_r5_we_setup: assert property (@(posedge clk) disable iff (rst)
    !(&mem_we_n) |-> (!(&mem_cs_n) && mem_wdata_oe && $past(mem_wdata_oe)));

  a_r5_we_hold: assert property (@(posedge clk) disable iff (rst)
    (!(&$past(mem_we_n)) && &mem_we_n) |-> mem_wdata_oe);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    req_done |-> (&mem_cs_n && mem_oe_n && &mem_we_n && !mem_wdata_oe));

  a_r4_rdata_held: assert property (@(posedge clk) disable iff (rst)
    !req_done |-> $stable(req_rdata));

  a_r9_wait_only_on_write: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_we) |-> $stable(cfg_wait));
endmodule

bind emc_bus_ctrl emc_bus_ctrl_chk #(
  .DATA_W(DATA_W), .CS_N(CS_N), .WAIT_W(WAIT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_done     (req_done),
  .req_rdata    (req_rdata),
  .cfg_we       (cfg_we),
  .cfg_wait     (cfg_wait),
  .mem_wdata_oe (mem_wdata_oe),
  .mem_cs_n     (mem_cs_n),
  .mem_oe_n     (mem_oe_n),
  .mem_we_n     (mem_we_n)
);

// File: tb/emc_bus_ctrl_test.sv
module emc_bus_ctrl_test;
  localparam int ADDR_W  = 20;
  localparam int DATA_W  = 32;
  localparam int CS_N    = 4;
  localparam int WAIT_W  = 2;
  localparam int IADDR_W = 22;
  localparam int LANES   = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst;
  logic               req_valid, req_write;
  logic [IADDR_W-1:0] req_addr;
  logic [DATA_W-1:0]  req_wdata;
  logic [LANES-1:0]   req_be;
  logic               req_done;
  logic [DATA_W-1:0]  req_rdata;
  logic               cfg_we;
  logic [WAIT_W-1:0]  cfg_wdata, cfg_wait;
  logic [ADDR_W-1:0]  mem_addr;
  logic [DATA_W-1:0]  mem_wdata, mem_rdata;
  logic               mem_wdata_oe;
  logic [CS_N-1:0]    mem_cs_n;
  logic               mem_oe_n;
  logic [LANES-1:0]   mem_we_n;
  logic [DATA_W-1:0]  rd_word;

  // External memory model: drives the word only while the read strobe is low.
  assign mem_rdata = mem_oe_n ? '0 : rd_word;

  emc_bus_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_done(req_done), .req_rdata(req_rdata), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_wait(cfg_wait), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  int checks = 0;
  int fails = 0;
  int wait_model = 0;
  int cycles = 0;
  logic [DATA_W-1:0] last_rd = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CS_N-1:0] exp_cs(input logic [1:0] s);
    return ~(CS_N'(1) << s);
  endfunction

  function automatic int exp_len(input bit wr, input int w);
    return (wr ? 3 : 1) + w;
  endfunction

  function automatic logic [LANES-1:0] exp_we(input bit wr, input int k,
                                              input int len, input logic [LANES-1:0] be);
    return (wr && k >= 2 && k <= len - 1) ? ~be : '1;
  endfunction

  task automatic check_idle(input string req);
    chk(&mem_cs_n && mem_oe_n && &mem_we_n && !mem_wdata_oe, req, "strobes idle",
        {mem_cs_n, mem_oe_n, mem_we_n, mem_wdata_oe}, {4'hF, 1'b1, 4'hF, 1'b0});
  endtask

  task automatic cfg_write(input int v);
    cfg_we = 1'b1;
    cfg_wdata = WAIT_W'(v);
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    wait_model = v;
    chk(cfg_wait == WAIT_W'(v), "R9", "wait readback", cfg_wait, v);
  endtask

  // Called at a negedge; the request is accepted at the next posedge.
  task automatic access(input bit wr, input logic [IADDR_W-1:0] addr,
                        input logic [DATA_W-1:0] data, input logic [LANES-1:0] be,
                        input int new_wait);
    int len;
    logic [DATA_W-1:0] rw;
    len = exp_len(wr, wait_model);
    rw = $urandom;
    rd_word = rw;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data; req_be = be;
    @(posedge clk); @(negedge clk);
    for (int k = 1; k <= len; k++) begin
      chk(mem_cs_n == exp_cs(addr[21:20]) && mem_addr == addr[19:0], "R2",
          "select/address", {mem_cs_n, mem_addr}, {exp_cs(addr[21:20]), addr[19:0]});
      chk(mem_oe_n == wr && mem_wdata_oe == wr, wr ? "R5" : "R3", "read strobe/drive",
          {mem_oe_n, mem_wdata_oe}, {wr, wr});
      chk(mem_we_n == exp_we(wr, k, len, be), wr ? "R6" : "R3", "write enables",
          mem_we_n, exp_we(wr, k, len, be));
      if (wr) chk(mem_wdata == data, "R6", "write data", mem_wdata, data);
      chk(!req_done, "R7", "no early done", req_done, 0);
      // R8/R9: scramble request fields and optionally reprogram the wait count.
      cfg_we = (k == 1 && new_wait >= 0);
      cfg_wdata = WAIT_W'(new_wait);
      req_addr = IADDR_W'($urandom);
      req_write = 1'($urandom);
      req_be = LANES'($urandom);
      req_wdata = $urandom;
      @(posedge clk); @(negedge clk);
    end
    cfg_we = 1'b0;
    if (new_wait >= 0) wait_model = new_wait;
    chk(req_done, "R7", "done pulse", req_done, 1);
    check_idle("R7");
    if (!wr) last_rd = rw;
    chk(req_rdata == last_rd, "R4", "read word", req_rdata, last_rd);
    @(posedge clk); @(negedge clk);
    chk(!req_done, "R8", "single done", req_done, 0);
    check_idle("R8");
    chk(req_rdata == last_rd, "R4", "read word held", req_rdata, last_rd);
    req_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_be = '0; cfg_we = 1'b0; cfg_wdata = '0; rd_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1");
    chk(!req_done && cfg_wait == '0, "R1", "done/wait in reset", {req_done, cfg_wait}, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check_idle("R1");
    chk(!req_done && cfg_wait == '0, "R1", "after reset", {req_done, cfg_wait}, 0);

    // Directed: every wait count, every select, both directions.
    for (int w = 0; w < 4; w++) begin
      cfg_write(w);
      access(1'b0, {2'(w), 20'h12345 + 20'(w)}, '0, '0, -1);
      access(1'b1, {2'(3 - w), 20'hABCDE - 20'(w)}, 32'hA5A5_0000 + w, 4'hF, -1);
    end
    // Byte masks: empty, single lane, split.
    cfg_write(0);
    access(1'b1, 22'h0_0010, 32'h1111_2222, 4'h0, -1);
    access(1'b1, 22'h1_0020, 32'h3333_4444, 4'h4, -1);
    access(1'b1, 22'h2_0030, 32'h5555_6666, 4'h9, -1);
    // Wait change during an access applies only afterwards (R9).
    access(1'b0, 22'h3_0040, '0, '0, 3);
    chk(cfg_wait == 2'd3, "R9", "wait after mid-access write", cfg_wait, 3);
    access(1'b1, 22'h0_0050, 32'hCAFE_F00D, 4'h6, 1);
    access(1'b0, 22'h1_0060, '0, '0, -1);

    // Random mix.
    for (int i = 0; i < 80; i++) begin
      if ($urandom % 6 == 0) cfg_write(int'($urandom % 4));
      access(1'($urandom), IADDR_W'($urandom), $urandom, LANES'($urandom),
             ($urandom % 8 == 0) ? int'($urandom % 4) : -1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule